// File: doc/BRIEF.md
# Receive Word Aligner with Gated Realignment

The block sits behind a deserializer that delivers parallel words of 8 or 10 bits with an unknown bit phase. Each accepted word is added to a three-word search window. Every bit offset inside one word width is compared at once against a programmable alignment pattern. The output stream is re-cut at the locked offset, so that each emitted word starts on the chosen boundary. The first received bit of a word is bit 0, and pattern bit 0 is the first pattern bit on the line.

Realignment is gated by an enable pin. In level mode (`EDGE_ARM=0`, used with 10-bit words and the K28.5 pattern), a match may move the boundary on any beat where the enable is high. In edge mode (`EDGE_ARM=1`, used with 8-bit words and the 16-bit pattern 16'h28F6), a match may move the boundary only if a rising edge of the enable has been seen since the last alignment. That edge is recorded in an armed flag, and the flag is consumed when an alignment happens. If the enable is already high in the first cycle after reset, this counts as a rising edge. Once a boundary is locked, a pattern found at any other offset is ignored unless realignment is permitted. Each output beat carries two flags. `m_sync` marks a beat on which a new alignment was taken. `m_detect` marks a beat on which the pattern sits on the boundary used for that beat.

Both data sides use valid/ready. A beat is accepted when `s_valid && s_ready`. The block has one output register, so `s_ready` is high whenever that register is empty or is being drained (`!m_valid || m_ready`). A beat held by `m_ready` low keeps its data and flags unchanged.

Top module: `rx_word_aligner`

## Requirements
- R1: Reset behaviour. After a synchronous reset, `m_valid`, `m_sync` and `m_detect` are low, no boundary is locked, and the output offset is 0.
- R2: Search. On each accepted word, the window is {new word, previous word, word before that}, with the oldest bit at index 0. The pattern is tested at every offset o from 0 to WORD_W-1 at window bits [o +: PAT_W]. If several offsets match, the lowest one is taken.
- R3: Alignment beat. On an alignment, the beat emitted for that input word is window bits [o+PAT_W-WORD_W +: WORD_W], which is the last WORD_W bits of the pattern. Both `m_sync` and `m_detect` are high on that beat.
- R4: Level mode. With EDGE_ARM=0, a match on a beat accepted while `align_en` is high is an alignment.
- R5: Edge mode. With EDGE_ARM=1, a match is an alignment only if a rising edge of `align_en` occurred since the last alignment. That edge may fall in the same cycle as the match, or in any earlier cycle, including stalled cycles. The alignment consumes the edge.
- R6: Lock hold. Without permission, a pattern at a non-locked offset changes neither the offset nor the flags.
- R7: Detect only. Without permission, a pattern at the locked offset raises `m_detect` on its beat, with `m_sync` low.
- R8: Data path. The output beat for each accepted word is window bits [off+PAT_W-WORD_W +: WORD_W], where off is the offset in force after that word.
- R9: Handshake. `s_ready` equals `!m_valid || m_ready`. `m_valid` stays high, and data and flags stay stable, while `m_ready` is low.
- R10: Flags are low whenever `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| align_en | input | 1 | Realignment permission (level or rising edge, per EDGE_ARM) |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with s_valid |
| s_data | input | WORD_W | Unaligned word from the deserializer |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_data | output | WORD_W | Word re-cut on the locked boundary |
| m_sync | output | 1 | Beat carries a new alignment |
| m_detect | output | 1 | Pattern present on the boundary of this beat |

## Verification
The hardest state to reach is a locked aligner that meets the pattern exactly on its own boundary while realignment is forbidden. This case must give a detect flag without a sync flag. The stimulus reaches it by tracking the model's locked offset and the absolute bit count of the stream. It inserts just enough random padding bits that the next pattern starts at a position congruent to that offset. A second hard case in edge mode is a pattern that arrives while the enable is still high from an earlier, already consumed edge. The stimulus creates it by leaving the enable high after the first lock and then placing a pattern at a shifted offset.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;
  // Number of parallel words kept in the search window (new word plus history).
  localparam int WIN_WORDS = 3;

  function automatic int win_width(input int word_w);
    return WIN_WORDS * word_w;
  endfunction

  // Per-beat side-band flags.
  typedef struct packed {
    logic sync;
    logic detect;
  } beat_flags_t;
endpackage

// File: rtl/rxwa_history.sv
module rxwa_history #(
  parameter int WORD_W = 10,
  parameter int WIN_W  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [WORD_W-1:0] din,
  output logic [WIN_W-1:0]  win
);
  localparam int HIST = WIN_W / WORD_W - 1;

  logic [WORD_W-1:0] stage [HIST];

  // Stage 0 holds the most recent accepted word; each later stage is one word older.
  for (genvar g = 0; g < HIST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else if (adv) stage[g] <= (g == 0) ? din : stage[(g == 0) ? 0 : g - 1];
    end
    // Oldest word occupies the lowest bits of the window.
    assign win[(HIST - 1 - g) * WORD_W +: WORD_W] = stage[g];
  end

  assign win[HIST * WORD_W +: WORD_W] = din;
endmodule

// File: rtl/rxwa_search.sv
module rxwa_search #(
  parameter int                 WORD_W  = 10,
  parameter int                 PAT_W   = 10,
  parameter logic [PAT_W-1:0]   PATTERN = 10'b0101111100,
  parameter int                 WIN_W   = 30,
  parameter int                 OFF_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_W-1:0]  win,
  output logic [WORD_W-1:0] hit,
  output logic              found,
  output logic [OFF_W-1:0]  first_off
);
  logic [WORD_W-1:0] pick_oh;

  // One comparator per candidate offset.
  for (genvar o = 0; o < WORD_W; o++) begin : g_cmp
    assign hit[o] = (win[o +: PAT_W] == PATTERN);
  end

  // Lowest matching offset wins: scan downward so the last write is the lowest.
  always_comb begin
    first_off = '0;
    pick_oh   = '0;
    for (int o = WORD_W - 1; o >= 0; o--) begin
      if (hit[o]) begin
        first_off = OFF_W'(o);
        pick_oh   = WORD_W'(1) << o;
      end
    end
  end

  assign found = |hit;

  // R2: at most one offset is picked, and no lower offset also matched.
  a_r2_single_pick: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh));
  a_r2_lowest_pick: assert property (@(posedge clk) disable iff (rst)
    (pick_oh != '0) |-> ((hit & (pick_oh - WORD_W'(1))) == '0));
endmodule

// File: rtl/rxwa_permit.sv
module rxwa_permit #(
  parameter bit EDGE_ARM = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic adv,
  input  logic found,
  output logic allow
);
  if (EDGE_ARM) begin : g_edge
    logic en_q;
    logic armed;
    logic rise;

    assign rise  = en && !en_q;
    assign allow = armed || rise;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  <= 1'b0;
        armed <= 1'b0;
      end else begin
        en_q  <= en;
        // An edge is remembered until an alignment uses it.
        armed <= (armed || rise) && !(adv && found);
      end
    end

    // R5: the armed flag only comes up after an observed low-to-high change.
    a_r5_arm_from_edge: assert property (@(posedge clk) disable iff (rst)
      $rose(armed) |-> ($past(en) && !$past(en_q)));
    // R5: an alignment taken on an accepted beat clears the flag.
    a_r5_arm_consumed: assert property (@(posedge clk) disable iff (rst)
      (adv && found && allow) |=> !armed);
  end else begin : g_level
    assign allow = en;
  end
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
  import rxwa_pkg::*;
#(
  parameter int               WORD_W   = 10,
  parameter int               PAT_W    = 10,
  parameter logic [PAT_W-1:0] PATTERN  = 10'b0101111100,
  parameter bit               EDGE_ARM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              align_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_sync,
  output logic              m_detect
);
  localparam int WIN_W = win_width(WORD_W);
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int IDX_W = $clog2(WIN_W);
  localparam int LEAD  = PAT_W - WORD_W;

  logic [WIN_W-1:0]  win;
  logic [WORD_W-1:0] hit;
  logic              found;
  logic [OFF_W-1:0]  first_off;
  logic              allow;
  logic              adv;
  logic              align;
  logic              locked;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  next_off;
  logic [IDX_W-1:0]  pick;
  beat_flags_t       flags_n;
  beat_flags_t       flags_q;

  assign s_ready = !m_valid || m_ready;
  assign adv     = s_valid && s_ready;

  rxwa_history #(.WORD_W(WORD_W), .WIN_W(WIN_W)) hist_i (
    .clk(clk), .rst(rst), .adv(adv), .din(s_data), .win(win)
  );

  rxwa_search #(.WORD_W(WORD_W), .PAT_W(PAT_W), .PATTERN(PATTERN),
                .WIN_W(WIN_W), .OFF_W(OFF_W)) search_i (
    .clk(clk), .rst(rst), .win(win), .hit(hit), .found(found), .first_off(first_off)
  );

  rxwa_permit #(.EDGE_ARM(EDGE_ARM)) permit_i (
    .clk(clk), .rst(rst), .en(align_en), .adv(adv), .found(found), .allow(allow)
  );

  assign align          = allow && found;
  assign next_off       = align ? first_off : off;
  assign pick           = IDX_W'(next_off) + IDX_W'(LEAD);
  assign flags_n.sync   = align;
  assign flags_n.detect = align || (locked && hit[off]);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      flags_q <= '0;
      locked  <= 1'b0;
      off     <= '0;
    end else if (adv) begin
      m_valid <= 1'b1;
      m_data  <= win[pick +: WORD_W];
      flags_q <= flags_n;
      locked  <= locked || align;
      off     <= next_off;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      flags_q <= '0;
    end
  end

  assign m_sync   = flags_q.sync;
  assign m_detect = flags_q.detect;

  // R3: a sync beat is always a detect beat.
  a_r3_sync_has_detect: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_sync) |-> m_detect);
  // R9: a stalled beat is held unchanged.
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sync) && $stable(m_detect)));
  // R10: no flag without a valid beat.
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> (!m_sync && !m_detect));
  // R6: without permission on an accepted beat the locked offset does not move.
  a_r6_offset_held: assert property (@(posedge clk) disable iff (rst)
    (locked && !(adv && allow)) |=> $stable(off));
  // R1: the first lock after reset is announced by a sync beat.
  a_r1_first_lock_synced: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> m_sync);
endmodule

// File: tb/rxwa_env.sv
module rxwa_env #(
  parameter int               WORD_W   = 10,
  parameter int               PAT_W    = 10,
  parameter logic [PAT_W-1:0] PATTERN  = 10'b0101111100,
  parameter bit               EDGE_ARM = 1'b0,
  parameter string            NAME     = "w10"
) (
  input  logic clk,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  logic              rst;
  logic              align_en;
  logic              s_valid;
  logic              s_ready;
  logic [WORD_W-1:0] s_data;
  logic              m_valid;
  logic              m_ready;
  logic [WORD_W-1:0] m_data;
  logic              m_sync;
  logic              m_detect;

  rx_word_aligner #(.WORD_W(WORD_W), .PAT_W(PAT_W), .PATTERN(PATTERN), .EDGE_ARM(EDGE_ARM)) dut_i (
    .clk(clk), .rst(rst), .align_en(align_en), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sync(m_sync), .m_detect(m_detect)
  );

  // ---------------- behavioural reference ----------------
  bit hbits[$];
  bit mv, ms, mdt, mlock, marm, mprev, rise, acc, ok;
  int moff, first, base, k;
  logic [WORD_W-1:0] md;
  bit started;
  string tag;
  int sync_seen, det_seen;
  int rmode;

  function automatic bit gb(int p);
    return (p < 0) ? 1'b0 : hbits[p];
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      mv = 0; ms = 0; mdt = 0; md = '0; mlock = 0; moff = 0; marm = 0; mprev = 0;
      hbits.delete();
    end else begin
      rise  = align_en && !mprev;
      mprev = align_en;
      acc   = s_valid && (!mv || m_ready);
      if (acc) begin
        for (int i = 0; i < WORD_W; i++) hbits.push_back(s_data[i]);
        k     = hbits.size() / WORD_W - 1;
        base  = (k - 2) * WORD_W;
        first = -1;
        for (int o = WORD_W - 1; o >= 0; o--) begin
          ok = 1;
          for (int j = 0; j < PAT_W; j++) if (gb(base + o + j) != PATTERN[j]) ok = 0;
          if (ok) first = o;
        end
        ok = 1;
        for (int j = 0; j < PAT_W; j++) if (gb(base + moff + j) != PATTERN[j]) ok = 0;
        ms  = (EDGE_ARM ? (marm || rise) : align_en) && (first >= 0);
        mdt = ms || (mlock && ok);
        if (EDGE_ARM) marm = (marm || rise) && !(first >= 0);
        if (ms) begin moff = first; mlock = 1; end
        for (int i = 0; i < WORD_W; i++) md[i] = gb(base + moff + PAT_W - WORD_W + i);
        mv = 1;
      end else begin
        marm = marm || rise;
        if (m_ready) begin mv = 0; ms = 0; mdt = 0; end
      end
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", NAME, rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(rst ? "R1" : "R9", "m_valid", int'(m_valid), int'(mv));
      chk("R9", "s_ready", int'(s_ready), int'(!mv || m_ready));
      if (mv) begin
        chk(tag == "R9" ? "R8" : tag, "m_data", int'(m_data), int'(md));
        chk(ms ? "R3" : tag, "m_sync", int'(m_sync), int'(ms));
        chk(tag, "m_detect", int'(m_detect), int'(mdt));
      end else begin
        chk(rst ? "R1" : "R10", "m_sync idle", int'(m_sync), 0);
        chk(rst ? "R1" : "R10", "m_detect idle", int'(m_detect), 0);
      end
      if (m_valid && m_ready && m_sync)   sync_seen++;
      if (m_valid && m_ready && m_detect) det_seen++;
    end
  end

  // ---------------- stimulus ----------------
  bit pend[$];

  always @(posedge clk) begin
    #2;
    m_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic add_rand(int n);
    for (int i = 0; i < n; i++) pend.push_back(1'($urandom));
  endtask

  task automatic add_pat();
    for (int j = 0; j < PAT_W; j++) pend.push_back(PATTERN[j]);
  endtask

  task automatic send_one();
    logic [WORD_W-1:0] w;
    bit got;
    if (pend.size() < WORD_W) add_rand(WORD_W - pend.size());
    for (int i = 0; i < WORD_W; i++) w[i] = pend.pop_front();
    if (rmode != 0) begin
      while (($urandom % 4) == 0) begin
        s_valid = 0;
        @(posedge clk); #2;
      end
    end
    s_valid = 1; s_data = w;
    got = 0;
    while (!got) begin
      @(negedge clk); got = s_ready;
      @(posedge clk); #2;
    end
    s_valid = 0;
  endtask

  task automatic flush(int extra);
    while (pend.size() > 0) send_one();
    for (int i = 0; i < extra; i++) send_one();
  endtask

  // Padding that puts the next queued bit on the model's locked boundary.
  function automatic int pad_to_lock();
    int pos = hbits.size() + pend.size();
    return ((moff - pos) % WORD_W + WORD_W) % WORD_W;
  endfunction

  int s0, d0;

  initial begin
    done = 0; n_chk = 0; n_bad = 0; rmode = 0; tag = "R1";
    rst = 1; align_en = 0; s_valid = 0; s_data = '0; sync_seen = 0; det_seen = 0;
    repeat (5) @(posedge clk);
    #2 rst = 0;
    repeat (4) @(posedge clk);
    #2;

    // No permission yet: a pattern must not lock.
    tag = "R6"; s0 = sync_seen;
    add_rand(7); add_pat(); flush(3);
    chk("R6", "sync count before permission", sync_seen - s0, 0);

    // First alignment.
    tag = EDGE_ARM ? "R5" : "R4"; s0 = sync_seen;
    if (EDGE_ARM) begin align_en = 0; send_one(); align_en = 1; end
    else align_en = 1;
    add_rand(3); add_pat(); flush(3);
    chk(tag, "sync count after permission", (sync_seen - s0) >= 1, 1);
    if (!EDGE_ARM) align_en = 0;

    // Locked: pattern at a shifted offset is ignored (enable stays high in edge mode).
    tag = "R6"; s0 = sync_seen; d0 = det_seen;
    add_rand(pad_to_lock() + 3); add_pat(); flush(3);
    chk("R6", "sync count shifted pattern", sync_seen - s0, 0);

    // Locked: pattern on the boundary gives detect only.
    tag = "R7"; s0 = sync_seen; d0 = det_seen;
    add_rand(pad_to_lock() + WORD_W); add_pat(); flush(3);
    chk("R7", "detect count on boundary", (det_seen - d0) >= 1, 1);
    chk("R7", "sync count on boundary", sync_seen - s0, 0);

    // Plain data after lock.
    tag = "R8";
    flush(40);

    // Back-pressure and gaps, with a realignment inside.
    tag = "R9"; rmode = 1; s0 = sync_seen;
    flush(20);
    if (EDGE_ARM) begin align_en = 0; send_one(); align_en = 1; end
    else align_en = 1;
    add_rand(5); add_pat(); flush(4);
    if (!EDGE_ARM) align_en = 0;
    flush(40);
    chk("R3", "sync count under stalls", (sync_seen - s0) >= 1, 1);

    // Random tail: toggling enable, scattered patterns.
    tag = "R2";
    for (int t = 0; t < 200; t++) begin
      align_en = (($urandom % 5) == 0);
      if (($urandom % 6) == 0) begin add_rand($urandom % WORD_W); add_pat(); end
      send_one();
    end
    align_en = 0; rmode = 0;
    flush(4);
    repeat (4) @(posedge clk);
    done = 1;
  end
endmodule

// File: tb/rx_word_aligner_tb_top.sv
module rx_word_aligner_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic done10, done8;
  int   chk10, bad10, chk8, bad8;

  rxwa_env #(.WORD_W(10), .PAT_W(10), .PATTERN(10'b0101111100), .EDGE_ARM(1'b0), .NAME("w10lvl")) env10_i (
    .clk(clk), .done(done10), .n_chk(chk10), .n_bad(bad10)
  );

  rxwa_env #(.WORD_W(8), .PAT_W(16), .PATTERN(16'h28F6), .EDGE_ARM(1'b1), .NAME("w8edge")) env8_i (
    .clk(clk), .done(done8), .n_chk(chk8), .n_bad(bad8)
  );

  int cycles = 0;

  initial begin
    int total, bad;
    while (!(done10 === 1'b1 && done8 === 1'b1) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    total = chk10 + chk8;
    bad   = bad10 + bad8;
    if (cycles >= 100000) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=<%0d", cycles, 100000);
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule